// File: doc/BRIEF.md
# Priority Group Pattern Sensor

This block watches a vector of input signals and tests it against a pattern held in configuration words. Each input has a 2-bit term code in every one of four priority groups. Two codes sense the input: one is true when the input is high, the other when it is low. The other two codes replace the input with a constant 1 or a constant 0. For each group, the block reduces all terms through a wide AND and, in parallel, through a wide OR. It registers both results, giving eight result bits per clock.

Software loads the patterns through a plain write port: an address, a 32-bit data word and a write enable. One word covers eight inputs of one group, and each group has enough words to cover the full input width. The width is set by a parameter, up to 140 signals. A downstream condition decoder uses the AND result to spot an exact pattern. It uses the OR result to spot any one of a set of signals being active.

Top module: `prio_pattern_sense`

## Requirements
- R1: In a configuration word with word index w, the term code for input 8*w+k (k = 0..7) is taken from bits 4k+1:4k. The other two bits of each 4-bit slot are not used.
- R2: Code 2'b11 gives a term that is true when its input is 1. Code 2'b10 gives a term that is true when its input is 0.
- R3: Code 2'b01 gives a constant-1 term and code 2'b00 gives a constant-0 term. Each term feeds both reductions of its group.
- R4: `grp_and[g]` is the AND of all NUM_IN terms of group g, and `grp_or[g]` is the OR of the same terms.
- R5: The four groups are configured independently. `cfg_addr` holds the group number in its top 2 bits and the word index in its low WIDX_W bits (WIDX_W = 2 by default, giving address = 4*group + word). A write changes only the addressed word.
- R6: Outputs are registered. The value present after clock edge N is computed from `sense_in` and the configuration as they stand at edge N.
- R7: A write sampled at edge N takes effect at that edge. The result registered at edge N still uses the old word, and the new word first shows in the result registered at edge N+1.
- R8: While `rst` is high at an edge, all outputs become 0 and every configuration word is cleared to 0. After reset, with no write, every output therefore reads 0.
- R9: A write whose word index is not below the number of words per group is ignored. Code slots that fall beyond input NUM_IN-1 in the last word have no effect.
- R10: With group 0 word 0 = 0x11113232 and all its other words = 0x11111111, `grp_and[0]` is 1 exactly when `sense_in[3:0]` == 4'hA.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write enable |
| cfg_addr | input | ADDR_W | Group number (high bits) and word index (low bits) |
| cfg_wdata | input | 32 | Configuration word |
| sense_in | input | NUM_IN | Input signals under test |
| grp_and | output | 4 | Registered AND result per group |
| grp_or | output | 4 | Registered OR result per group |

## Verification
Each result is due one edge after the inputs it depends on. A configuration write is due one edge later still, because the word is stored at the write edge and read at the next one. The reference model computes the expected results from the configuration it holds before each edge and compares them just after that edge. Only then does it apply the write of that cycle to its own copy. This follows the R6 and R7 timing on every clock, including cycles where a write and an input change fall on the same edge.

// File: rtl/psense_pkg.sv
package psense_pkg;
  localparam int CFG_WORD_W  = 32;
  localparam int SLOT_W      = 4;
  localparam int CODE_W      = 2;
  localparam int LANES       = CFG_WORD_W / SLOT_W;
  localparam int NUM_GROUPS  = 4;
  localparam int GRP_W       = 2;

  typedef enum logic [CODE_W-1:0] {
    TERM_ZERO = 2'b00,
    TERM_ONE  = 2'b01,
    TERM_LOW  = 2'b10,
    TERM_HIGH = 2'b11
  } term_code_e;

  function automatic logic term_eval(input logic [CODE_W-1:0] code, input logic bit_in);
    logic r;
    case (term_code_e'(code))
      TERM_ZERO: r = 1'b0;
      TERM_ONE:  r = 1'b1;
      TERM_LOW:  r = ~bit_in;
      default:   r = bit_in;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/psense_cfg_bank.sv
module psense_cfg_bank
  import psense_pkg::*;
#(
  parameter int WPG    = 3,
  parameter int WIDX_W = 2,
  parameter int ADDR_W = 4,
  localparam int WORD_CODES_W = LANES * CODE_W,
  localparam int GROUP_CODES_W = WPG * WORD_CODES_W
) (
  input  logic                                  clk,
  input  logic                                  rst,
  input  logic                                  we,
  input  logic [ADDR_W-1:0]                     addr,
  input  logic [CFG_WORD_W-1:0]                 wdata,
  output logic [NUM_GROUPS*GROUP_CODES_W-1:0]   codes_flat
);
  localparam int NWORDS = NUM_GROUPS * WPG;

  logic [WORD_CODES_W-1:0] store_q [NWORDS];
  logic [WORD_CODES_W-1:0] packed_w;
  logic [GRP_W-1:0]        grp_sel;
  logic [WIDX_W-1:0]       widx_sel;
  logic                    idx_ok;
  int                      wr_idx;

  // keep only the code field of each slot
  always_comb begin
    for (int k = 0; k < LANES; k++) begin
      packed_w[k*CODE_W +: CODE_W] = wdata[k*SLOT_W +: CODE_W];
    end
  end

  logic unused_slot_bits;
  always_comb begin
    unused_slot_bits = 1'b0;
    for (int k = 0; k < LANES; k++) begin
      unused_slot_bits = unused_slot_bits ^ (^wdata[k*SLOT_W+CODE_W +: SLOT_W-CODE_W]);
    end
  end

  assign grp_sel  = addr[ADDR_W-1 -: GRP_W];
  assign widx_sel = addr[WIDX_W-1:0];
  assign idx_ok   = int'(widx_sel) < WPG;
  assign wr_idx   = int'(grp_sel) * WPG + int'(widx_sel);

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NWORDS; i++) store_q[i] <= '0;
    end else if (we && idx_ok) begin
      store_q[wr_idx] <= packed_w;
    end
  end

  for (genvar i = 0; i < NWORDS; i++) begin : g_flat
    assign codes_flat[i*WORD_CODES_W +: WORD_CODES_W] = store_q[i];
  end
endmodule

// File: rtl/psense_group.sv
module psense_group
  import psense_pkg::*;
#(
  parameter int NUM_IN = 20,
  parameter int WPG    = 3,
  localparam int CODES_W = WPG * LANES * CODE_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [CODES_W-1:0] codes,
  input  logic [NUM_IN-1:0]  sense_in,
  output logic               and_q,
  output logic               or_q
);
  logic [NUM_IN-1:0] terms;

  for (genvar j = 0; j < NUM_IN; j++) begin : g_term
    assign terms[j] = term_eval(codes[j*CODE_W +: CODE_W], sense_in[j]);
  end

  if (CODES_W > NUM_IN * CODE_W) begin : g_spare
    logic unused_spare;
    assign unused_spare = ^codes[CODES_W-1:NUM_IN*CODE_W];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      and_q <= 1'b0;
      or_q  <= 1'b0;
    end else begin
      and_q <= &terms;
      or_q  <= |terms;
    end
  end
endmodule

// File: rtl/prio_pattern_sense.sv
module prio_pattern_sense
  import psense_pkg::*;
#(
  parameter int NUM_IN = 20,
  localparam int WPG    = (NUM_IN + LANES - 1) / LANES,
  localparam int WIDX_W = (WPG > 1) ? $clog2(WPG) : 1,
  localparam int ADDR_W = GRP_W + WIDX_W
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  cfg_we,
  input  logic [ADDR_W-1:0]     cfg_addr,
  input  logic [CFG_WORD_W-1:0] cfg_wdata,
  input  logic [NUM_IN-1:0]     sense_in,
  output logic [NUM_GROUPS-1:0] grp_and,
  output logic [NUM_GROUPS-1:0] grp_or
);
  localparam int GCW = WPG * LANES * CODE_W;

  logic [NUM_GROUPS*GCW-1:0] codes_flat;

  psense_cfg_bank #(.WPG(WPG), .WIDX_W(WIDX_W), .ADDR_W(ADDR_W)) u_bank (
    .clk        (clk),
    .rst        (rst),
    .we         (cfg_we),
    .addr       (cfg_addr),
    .wdata      (cfg_wdata),
    .codes_flat (codes_flat)
  );

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
    psense_group #(.NUM_IN(NUM_IN), .WPG(WPG)) u_grp (
      .clk      (clk),
      .rst      (rst),
      .codes    (codes_flat[g*GCW +: GCW]),
      .sense_in (sense_in),
      .and_q    (grp_and[g]),
      .or_q     (grp_or[g])
    );
  end
endmodule

// File: rtl/psense_checker.sv
module psense_checker #(
  parameter int NUM_IN = 20,
  localparam int WPG    = (NUM_IN + 7) / 8,
  localparam int WIDX_W = (WPG > 1) ? $clog2(WPG) : 1,
  localparam int ADDR_W = 2 + WIDX_W
) (
  input logic              clk,
  input logic              rst,
  input logic              cfg_we,
  input logic [ADDR_W-1:0] cfg_addr,
  input logic [NUM_IN-1:0] sense_in,
  input logic [3:0]        grp_and,
  input logic [3:0]        grp_or
);
  logic touched_q;
  logic wr_valid;

  assign wr_valid = cfg_we && (int'(cfg_addr[WIDX_W-1:0]) < WPG);

  always_ff @(posedge clk) begin
    if (rst) touched_q <= 1'b0;
    else if (wr_valid) touched_q <= 1'b1;
  end

  AST_RESET_ZERO: assert property (@(posedge clk) rst |=> (grp_and == 4'd0 && grp_or == 4'd0)); // R8

  AST_QUIET_UNTIL_WRITE: assert property (@(posedge clk) disable iff (rst)
    !touched_q |=> (grp_and == 4'd0 && grp_or == 4'd0)); // R9

  AST_HOLD_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst)
    (!$past(cfg_we) && $stable(sense_in)) |=> ($stable(grp_and) && $stable(grp_or))); // R6

  AST_AND_WITHIN_OR: assert property (@(posedge clk) disable iff (rst)
    (grp_and & ~grp_or) == 4'd0); // R4
endmodule

bind prio_pattern_sense psense_checker #(.NUM_IN(NUM_IN)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .cfg_we   (cfg_we),
  .cfg_addr (cfg_addr),
  .sense_in (sense_in),
  .grp_and  (grp_and),
  .grp_or   (grp_or)
);

// File: tb/prio_pattern_sense_bench.sv
module prio_pattern_sense_bench;
  localparam int NUM_IN = 20;
  localparam int WPG    = 3;
  localparam int WIDX_W = 2;
  localparam int ADDR_W = 4;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              cfg_we = 1'b0;
  logic [ADDR_W-1:0] cfg_addr = '0;
  logic [31:0]       cfg_wdata = '0;
  logic [NUM_IN-1:0] sense_in = '0;
  logic [3:0]        grp_and;
  logic [3:0]        grp_or;

  int total = 0;
  int bad = 0;
  bit done = 0;
  bit [31:0] m_cfg [4][WPG];

  always #5 clk = ~clk;

  prio_pattern_sense #(.NUM_IN(NUM_IN)) u_prio_pattern_sense (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .sense_in(sense_in), .grp_and(grp_and), .grp_or(grp_or)
  );

  function automatic void model_eval(input bit [NUM_IN-1:0] v, output bit [3:0] ea, output bit [3:0] eo);
    for (int g = 0; g < 4; g++) begin
      bit all1 = 1;
      bit any1 = 0;
      for (int j = 0; j < NUM_IN; j++) begin
        int code = (m_cfg[g][j/8] >> (4*(j%8))) & 3;
        bit t = (code == 1) ? 1'b1 : (code == 0) ? 1'b0 : (code == 3) ? v[j] : !v[j];
        all1 &= t;
        any1 |= t;
      end
      ea[g] = all1;
      eo[g] = any1;
    end
  endfunction

  // one clock: drive, edge, compare, then update the model
  task automatic cycle(input bit r, input bit we, input int addr, input bit [31:0] data,
                       input bit [NUM_IN-1:0] v, input string tag);
    bit [3:0] ea, eo;
    rst = r; cfg_we = we; cfg_addr = ADDR_W'(addr); cfg_wdata = data; sense_in = v;
    if (r) begin ea = 0; eo = 0; end
    else model_eval(v, ea, eo);
    @(posedge clk);
    #1;
    total++;
    if (grp_and !== ea || grp_or !== eo) begin
      bad++;
      $display("FAIL %s: and=%b or=%b expected and=%b or=%b", tag, grp_and, grp_or, ea, eo);
    end
    if (r) begin
      for (int g = 0; g < 4; g++) for (int w = 0; w < WPG; w++) m_cfg[g][w] = 0;
    end else if (we && (addr % 4) < WPG) begin
      m_cfg[addr / 4][addr % 4] = data;
    end
    @(negedge clk);
  endtask

  task automatic wr(input int g, input int w, input bit [31:0] d, input string tag);
    cycle(0, 1, g*4 + w, d, NUM_IN'($urandom), tag);
  endtask

  task automatic idle(input bit [NUM_IN-1:0] v, input string tag);
    cycle(0, 0, 0, 0, v, tag);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: run did not end, expected end before limit");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int g = 0; g < 4; g++) for (int w = 0; w < WPG; w++) m_cfg[g][w] = 0;
    @(negedge clk);
    // R8 reset state
    for (int i = 0; i < 3; i++) cycle(1, 1, 1, 32'hFFFFFFFF, NUM_IN'($urandom), "R8 reset");
    for (int i = 0; i < 4; i++) idle(NUM_IN'($urandom), "R3 all code 00");

    // R10 / R7 pattern 0xA on group 0 (write cycle compares old config)
    wr(0, 0, 32'h11113232, "R7 write edge");
    wr(0, 1, 32'h11111111, "R7");
    wr(0, 2, 32'h11111111, "R7");
    wr(0, 3, 32'h00000000, "R9 bad index");
    for (int n = 0; n < 16; n++) idle({NUM_IN'($urandom) & ~NUM_IN'(15)} | NUM_IN'(n), "R10 nibble sweep");

    // R1 slot position: group 1 word 1 lane 1 senses input 9
    wr(1, 1, 32'h000000F0 & 32'h00000030, "R1");
    idle(NUM_IN'(1) << 9, "R1 input 9 high");
    idle(~(NUM_IN'(1) << 9), "R1 input 9 low");
    idle('0, "R1 zero");

    // R2 low-sense on group 2
    for (int w = 0; w < WPG; w++) wr(2, w, 32'h22222222, "R2");
    idle('0, "R2 all low");
    idle('1, "R2 all high");
    idle(NUM_IN'(1) << 5, "R2 one high");

    // R9 unused bits and lanes past NUM_IN on group 3
    wr(3, 0, 32'hDDDDDDDD, "R9");
    wr(3, 1, 32'hDDDDDDDD, "R9");
    wr(3, 2, 32'h00001111, "R9");
    for (int i = 0; i < 4; i++) idle(NUM_IN'($urandom), "R9 ignored slots");

    // R5 write one group, all groups compared
    wr(2, 0, 32'h33333333, "R5");
    idle(NUM_IN'(8'hFF), "R5");
    idle(NUM_IN'(8'h0F), "R5");

    // R4 / R6 random configuration and inputs
    for (int i = 0; i < 60; i++) begin
      bit [31:0] d = $urandom;
      if ($urandom % 3 == 0) d = d | 32'h11111111;
      cycle(0, ($urandom % 2) == 1, int'($urandom % 16), d, NUM_IN'($urandom), "R4 random");
    end
    for (int i = 0; i < 5; i++) idle(NUM_IN'($urandom), "R6 hold");

    // R8 reset mid-run clears configuration
    cycle(1, 0, 0, 0, NUM_IN'($urandom), "R8 mid reset");
    for (int i = 0; i < 3; i++) idle(NUM_IN'($urandom), "R8 cleared");

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule